// File: doc/BRIEF.md
# Branch Target Instruction Cache

The block remembers, for recently taken branches, the first instructions found at each branch target. A fetch unit presents the target address of a taken or predicted-taken branch. If that target is cached, the block returns the first instruction and, when present, the second one on the very next clock. That is one cycle ahead of what the instruction cache could deliver. Along with the instructions it returns the address of the first instruction after the cached ones, so the instruction cache can take over the sequential stream in the following cycle.

Lookup is fully associative over a parameterised number of entries (64 by default). The tag is the word-aligned target address. Entries are written through a fill port that carries the target address, one or two instruction words, and a flag for the second word. Replacement follows a true least-recently-used order, and both hits and fills make an entry most recent. A single invalidate-all input empties the cache in one cycle.

Top module: `branch_target_insn_cache`

## Requirements
- R1: While and after reset every entry is invalid, and `hit_o`, `insn0_o`, `insn1_o`, `insn1_vld_o` and `next_addr_o` are all 0.
- R2: The result of a lookup presented in cycle t appears on the outputs in cycle t+1. `hit_o` can be 1 only when a lookup was presented in the previous cycle.
- R3: The tag is `lookup_addr_i[ADDR_W-1:2]`, so the two low address bits have no effect on hit or data.
- R4: On a hit, `next_addr_o` equals the word-aligned target plus 8 when the second word is valid, and plus 4 otherwise.
- R5: On a miss, or in a cycle with no lookup, `hit_o`, `insn0_o`, `insn1_o`, `insn1_vld_o` and `next_addr_o` are all 0.
- R6: A fill whose tag is already cached overwrites that entry in place, so no two valid entries ever share a tag.
- R7: A fill with a new tag goes into the least-recently-used entry. After reset the order is entry 0 most recent up to entry N-1 least recent, and never-filled entries are therefore used before valid ones.
- R8: Hits and fills both make the touched entry the most recent one.
- R9: Invalidate-all clears every entry in one cycle. A lookup in the same cycle misses, and a fill in the same cycle is discarded.
- R10: A lookup and a fill in the same cycle: the lookup sees the contents from before the fill, and only the fill updates recency.
- R11: An entry filled with one instruction (`fill_insn1_vld_i` = 0) reports `insn1_vld_o` = 0 and `insn1_o` = 0 on a hit.
- R12: All N entries hold N distinct targets at the same time, and each of them hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_vld_i | input | 1 | Lookup request this cycle |
| lookup_addr_i | input | ADDR_W | Branch target address to look up |
| fill_vld_i | input | 1 | Write an entry this cycle |
| fill_addr_i | input | ADDR_W | Target address of the entry being written |
| fill_insn0_i | input | 32 | First instruction at the target |
| fill_insn1_i | input | 32 | Second instruction at the target |
| fill_insn1_vld_i | input | 1 | Second instruction is present |
| inval_all_i | input | 1 | Invalidate every entry |
| hit_o | output | 1 | Previous-cycle lookup hit |
| insn0_o | output | 32 | First cached instruction |
| insn1_o | output | 32 | Second cached instruction |
| insn1_vld_o | output | 1 | Second instruction is valid |
| next_addr_o | output | ADDR_W | Address where the sequential fetch continues |

## Verification
Some properties hold on every cycle and are checked by assertions:
- Outputs stay quiet on a miss.
- A hit needs a lookup in the previous cycle, and never follows an invalidate.
- The next-fetch address is word-aligned.
- A single-word hit reports a zero second word.
- No two valid entries match one tag.
- Exactly one entry is ever marked oldest.

Other properties only show up through the scenarios run against the behavioural reference model:
- which entry a new fill evicts,
- how hits and fills reorder recency,
- that in-place overwrite keeps the new data,
- the ordering when a fill and a lookup land in the same cycle,
- the full-capacity case.

// File: rtl/btic_pkg.sv
package btic_pkg;
  parameter int unsigned BTIC_INSN_W = 32;
  typedef logic [BTIC_INSN_W-1:0] insn_t;
  typedef struct packed {
    insn_t i0;
    insn_t i1;
    logic  v1;
  } pair_t;
endpackage

// File: rtl/btic_onehot_enc.sv
module btic_onehot_enc #(
  parameter int unsigned N     = 64,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/btic_tag_cam.sv
module btic_tag_cam #(
  parameter int unsigned N     = 64,
  parameter int unsigned TAG_W = 30,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inval_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [TAG_W-1:0] lkp_tag_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  output logic [N-1:0]     lkp_match_o,
  output logic [N-1:0]     fill_match_o
);
  logic [N-1:0]     valid_q;
  logic [TAG_W-1:0] tag_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (inval_i) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !inval_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign lkp_match_o[g]  = valid_q[g] && (tag_q[g] == lkp_tag_i);
    assign fill_match_o[g] = valid_q[g] && (tag_q[g] == fill_tag_i);
  end
endmodule

// File: rtl/btic_lru.sv
module btic_lru #(
  parameter int unsigned N     = 64,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [N-1:0]     oldest_vec_o,
  output logic [IDX_W-1:0] victim_idx_o
);
  // age 0 = most recent; ages always form a permutation of 0..N-1
  logic [IDX_W-1:0] age_q [N];
  logic [IDX_W-1:0] touch_age;

  assign touch_age = age_q[touch_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (touch_idx_i == IDX_W'(i))  age_q[i] <= '0;
        else if (age_q[i] < touch_age) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest_vec_o[g] = (age_q[g] == IDX_W'(N-1));
  end

  btic_onehot_enc #(.N(N)) u_victim_enc (
    .vec_i (oldest_vec_o),
    .idx_o (victim_idx_o)
  );
endmodule

// File: rtl/btic_payload.sv
module btic_payload
  import btic_pkg::*;
#(
  parameter int unsigned N     = 64,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  pair_t            wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output pair_t            rd_data_o
);
  pair_t mem_q [N];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/branch_target_insn_cache.sv
module branch_target_insn_cache
  import btic_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  parameter int unsigned ADDR_W      = 32,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
  localparam int unsigned TAG_W      = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_vld_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  input  logic              fill_vld_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [31:0]       fill_insn0_i,
  input  logic [31:0]       fill_insn1_i,
  input  logic              fill_insn1_vld_i,
  input  logic              inval_all_i,
  output logic              hit_o,
  output logic [31:0]       insn0_o,
  output logic [31:0]       insn1_o,
  output logic              insn1_vld_o,
  output logic [ADDR_W-1:0] next_addr_o
);
  logic [TAG_W-1:0]       lkp_tag, fill_tag;
  logic [NUM_ENTRIES-1:0] lkp_match, fill_match, oldest_vec;
  logic [IDX_W-1:0]       lkp_idx, fill_hit_idx, victim_idx, fill_idx, touch_idx;
  logic                   lkp_hit, wr_en, touch;
  pair_t                  wr_pair, rd_pair;

  assign lkp_tag  = lookup_addr_i[ADDR_W-1:2];
  assign fill_tag = fill_addr_i[ADDR_W-1:2];

  btic_tag_cam #(.N(NUM_ENTRIES), .TAG_W(TAG_W)) u_cam (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .inval_i      (inval_all_i),
    .wr_en_i      (wr_en),
    .wr_idx_i     (fill_idx),
    .wr_tag_i     (fill_tag),
    .lkp_tag_i    (lkp_tag),
    .fill_tag_i   (fill_tag),
    .lkp_match_o  (lkp_match),
    .fill_match_o (fill_match)
  );

  btic_onehot_enc #(.N(NUM_ENTRIES)) u_lkp_enc  (.vec_i(lkp_match),  .idx_o(lkp_idx));
  btic_onehot_enc #(.N(NUM_ENTRIES)) u_fill_enc (.vec_i(fill_match), .idx_o(fill_hit_idx));

  assign lkp_hit  = lookup_vld_i && !inval_all_i && (|lkp_match);
  assign wr_en    = fill_vld_i && !inval_all_i;
  // refill of a cached target stays in place; otherwise evict the oldest
  assign fill_idx = (|fill_match) ? fill_hit_idx : victim_idx;
  // fill owns the recency update when both arrive together
  assign touch     = wr_en || lkp_hit;
  assign touch_idx = wr_en ? fill_idx : lkp_idx;

  btic_lru #(.N(NUM_ENTRIES)) u_lru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_i      (touch),
    .touch_idx_i  (touch_idx),
    .oldest_vec_o (oldest_vec),
    .victim_idx_o (victim_idx)
  );

  assign wr_pair.i0 = fill_insn0_i;
  assign wr_pair.i1 = fill_insn1_i;
  assign wr_pair.v1 = fill_insn1_vld_i;

  btic_payload #(.N(NUM_ENTRIES)) u_data (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (fill_idx),
    .wr_data_i (wr_pair),
    .rd_idx_i  (lkp_idx),
    .rd_data_o (rd_pair)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o       <= 1'b0;
      insn0_o     <= '0;
      insn1_o     <= '0;
      insn1_vld_o <= 1'b0;
      next_addr_o <= '0;
    end else if (lkp_hit) begin
      hit_o       <= 1'b1;
      insn0_o     <= rd_pair.i0;
      insn1_o     <= rd_pair.v1 ? rd_pair.i1 : '0;
      insn1_vld_o <= rd_pair.v1;
      next_addr_o <= {lkp_tag, 2'b00} + ADDR_W'(rd_pair.v1 ? 8 : 4);
    end else begin
      hit_o       <= 1'b0;
      insn0_o     <= '0;
      insn1_o     <= '0;
      insn1_vld_o <= 1'b0;
      next_addr_o <= '0;
    end
  end
endmodule

// File: rtl/btic_checker.sv
module btic_checker #(
  parameter int unsigned NUM_ENTRIES = 64,
  parameter int unsigned ADDR_W      = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   lookup_vld_i,
  input logic                   inval_all_i,
  input logic                   hit_o,
  input logic [31:0]            insn0_o,
  input logic [31:0]            insn1_o,
  input logic                   insn1_vld_o,
  input logic [ADDR_W-1:0]      next_addr_o,
  input logic [NUM_ENTRIES-1:0] lkp_match_i,
  input logic [NUM_ENTRIES-1:0] oldest_vec_i
);
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  p_hit_needs_lookup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && hit_o |-> $past(lookup_vld_i));

  p_miss_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (insn0_o == '0 && insn1_o == '0 && !insn1_vld_o && next_addr_o == '0));

  p_next_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> next_addr_o[1:0] == 2'b00);

  p_unique_tag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_match_i));

  p_one_oldest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest_vec_i) == 1);

  p_inval_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && inval_all_i |=> !hit_o);

  p_single_word_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !insn1_vld_o |-> insn1_o == '0);
endmodule

bind branch_target_insn_cache btic_checker #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .ADDR_W      (ADDR_W)
) u_btic_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lookup_vld_i (lookup_vld_i),
  .inval_all_i  (inval_all_i),
  .hit_o        (hit_o),
  .insn0_o      (insn0_o),
  .insn1_o      (insn1_o),
  .insn1_vld_o  (insn1_vld_o),
  .next_addr_o  (next_addr_o),
  .lkp_match_i  (lkp_match),
  .oldest_vec_i (oldest_vec)
);

// File: tb/branch_target_insn_cache_tb_top.sv
module branch_target_insn_cache_tb_top;
  localparam int N  = 64;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lookup_vld = 1'b0;
  logic [AW-1:0] lookup_addr = '0;
  logic          fill_vld = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [31:0]   fill_i0 = '0, fill_i1 = '0;
  logic          fill_v1 = 1'b0;
  logic          inval = 1'b0;
  logic          hit;
  logic [31:0]   i0, i1;
  logic          v1;
  logic [AW-1:0] nxt;

  always #4 clk = ~clk;

  branch_target_insn_cache #(.NUM_ENTRIES(N), .ADDR_W(AW)) dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .lookup_vld_i (lookup_vld), .lookup_addr_i (lookup_addr),
    .fill_vld_i (fill_vld), .fill_addr_i (fill_addr),
    .fill_insn0_i (fill_i0), .fill_insn1_i (fill_i1), .fill_insn1_vld_i (fill_v1),
    .inval_all_i (inval),
    .hit_o (hit), .insn0_o (i0), .insn1_o (i1), .insn1_vld_o (v1), .next_addr_o (nxt)
  );

  int    total = 0, bad = 0;
  string cur_req = "R1";
  int    salt = 1;

  // reference model
  logic [AW-3:0] m_tag [N];
  bit            m_val [N];
  logic [31:0]   m_i0 [N], m_i1 [N];
  bit            m_v1 [N];
  int            lru_q [$];
  logic          e_hit;
  logic [31:0]   e_i0, e_i1;
  logic          e_v1;
  logic [AW-1:0] e_nxt;

  function automatic int m_find(logic [AW-3:0] t);
    for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic void m_touch(int k);
    for (int i = 0; i < lru_q.size(); i++) if (lru_q[i] == k) begin lru_q.delete(i); break; end
    lru_q.push_front(k);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      lru_q = {};
      for (int i = 0; i < N; i++) begin m_val[i] = 0; lru_q.push_back(i); end
      e_hit = 0; e_i0 = 0; e_i1 = 0; e_v1 = 0; e_nxt = 0;
    end else begin
      automatic int k = -1;
      automatic int f;
      if (lookup_vld && !inval) k = m_find(lookup_addr[AW-1:2]);
      if (k >= 0) begin
        e_hit = 1; e_i0 = m_i0[k]; e_v1 = m_v1[k]; e_i1 = m_v1[k] ? m_i1[k] : 0;
        e_nxt = {lookup_addr[AW-1:2], 2'b00} + (m_v1[k] ? 8 : 4);
      end else begin
        e_hit = 0; e_i0 = 0; e_i1 = 0; e_v1 = 0; e_nxt = 0;
      end
      if (inval) begin
        for (int i = 0; i < N; i++) m_val[i] = 0;
      end else if (fill_vld) begin
        f = m_find(fill_addr[AW-1:2]);
        if (f < 0) f = lru_q[lru_q.size()-1];
        m_val[f] = 1; m_tag[f] = fill_addr[AW-1:2];
        m_i0[f] = fill_i0; m_i1[f] = fill_i1; m_v1[f] = fill_v1;
        m_touch(f);
      end else if (k >= 0) m_touch(k);
    end
  end

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(hit === e_hit, "hit", 64'(hit), 64'(e_hit));
      chk(i0 === e_i0, "insn0", 64'(i0), 64'(e_i0));
      chk(i1 === e_i1, "insn1", 64'(i1), 64'(e_i1));
      chk(v1 === e_v1, "insn1_vld", 64'(v1), 64'(e_v1));
      chk(nxt === e_nxt, "next_addr", 64'(nxt), 64'(e_nxt));
    end else begin
      // R1: quiet outputs during reset
      chk(hit === 1'b0 && nxt === '0 && v1 === 1'b0, "reset outputs", 64'(hit), 64'd0);
    end
  end

  task automatic cyc(bit lv, logic [AW-1:0] la, bit fv, logic [AW-1:0] fa, bit fv1, bit inv);
    lookup_vld = lv; lookup_addr = la;
    fill_vld = fv; fill_addr = fa;
    fill_i0 = fa ^ 32'h5a00_0000 ^ salt; fill_i1 = fa ^ 32'h00c3_0000 ^ (salt << 8); fill_v1 = fv1;
    inval = inv;
    salt++;
    @(negedge clk);
  endtask

  task automatic look(logic [AW-1:0] a); cyc(1, a, 0, 0, 0, 0); endtask
  task automatic fill(logic [AW-1:0] a, bit two); cyc(0, 0, 1, a, two, 0); endtask

  function automatic logic [AW-1:0] ad(int i); return 32'h0001_0000 + 32'(i) * 32'h40; endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R5"; look(ad(0)); look(ad(1)); cyc(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0);
    cur_req = "R12";
    for (int i = 0; i < N; i++) fill(ad(i), 1);
    for (int i = 0; i < N; i++) look(ad(i));
    cur_req = "R2"; look(ad(5)); cyc(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0);
    cur_req = "R3"; look(ad(7) + 1); look(ad(8) + 3); look(ad(9) + 2);
    cur_req = "R11"; fill(ad(10), 0); look(ad(10)); look(ad(10) + 1);
    cur_req = "R4"; look(ad(11)); look(ad(10));
    cur_req = "R7"; fill(32'h0002_0000, 1); look(ad(0)); look(32'h0002_0000);
    cur_req = "R8"; look(ad(1)); fill(32'h0002_0040, 1); look(ad(1)); look(ad(2)); look(32'h0002_0040);
    cur_req = "R6"; fill(ad(20), 1); look(ad(20)); fill(ad(20) + 2, 0); look(ad(20));
    cur_req = "R10";
    cyc(1, ad(21), 1, ad(21), 1, 0); look(ad(21));
    cyc(1, 32'h0003_0000, 1, 32'h0003_0000, 1, 0); look(32'h0003_0000);
    cyc(1, ad(22), 1, 32'h0003_0040, 1, 0); fill(32'h0003_0080, 1); look(ad(22));
    cur_req = "R9";
    cyc(1, ad(23), 0, 0, 0, 1); look(ad(23));
    fill(ad(24), 1); cyc(1, ad(24), 1, ad(25), 1, 1); look(ad(24)); look(ad(25));
    cur_req = "R7";
    for (int i = 0; i < 4; i++) fill(ad(40 + i), i % 2 == 0);
    for (int i = 0; i < 4; i++) look(ad(40 + i));
    cur_req = "R8";
    for (int n = 0; n < 5000; n++) begin
      automatic int r = $urandom_range(0, 99);
      automatic logic [AW-1:0] a1 = ad($urandom_range(0, 79)) + 32'($urandom_range(0, 3));
      automatic logic [AW-1:0] a2 = ad($urandom_range(0, 79));
      cyc(r < 55, a1, r >= 40 && r < 97, a2, $urandom_range(0, 1) == 1, r >= 99);
    end
    cyc(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule